// File: doc/BRIEF.md
# Multi-line vectored interrupt arbiter

This block gathers interrupt requests from a group of serial terminal lines (up to sixteen by default). Every line owns three request flags: one for a received character, one for a change on its modem-status signals, and one for transmitter ready. It merges these flags into two master requests, one for the input side and one for the output side.

When the processor acknowledges one of the two sides, the block picks the lowest-numbered line that has a pending request on that side and clears it. One cycle later it presents an interrupt vector for that line on a registered output. Each line takes eight bytes of vector space above a programmable base. The input vector sits at the start of that slot and the output vector four bytes higher. Receive and modem-status requests share the input vector, so one input acknowledge retires both of them.

The number of lines in use can be set at run time. Lines above that count never raise a request. The block also reports how large the register window is for the configured number of lines.

Top module: `line_irq_arbiter`

## Requirements
- R1: Each line has three request bits: receive, modem-change and transmit. A set strobe on an enabled line sets its bit at the next clock edge. `in_req` is high whenever any receive or modem-change bit is set. `out_req` is high whenever any transmit bit is set.
- R2: In the cycle after an `in_ack`, `vec_out` equals `vec_base + 8*L`, taken modulo 2^VEC_W. L is the lowest line with a receive or modem-change bit set in the acknowledge cycle, and both of that line's input bits are cleared.
- R3: An `in_ack` arriving when no receive or modem-change bit is set makes `vec_out` zero in the next cycle and changes no request bit.
- R4: In the cycle after an `out_ack` (with `in_ack` low), `vec_out` equals `vec_base + 8*L + 4`. L is the lowest line with its transmit bit set, and only that transmit bit is cleared.
- R5: An `out_ack` arriving with `in_ack` low and no transmit bit set makes `vec_out` zero in the next cycle.
- R6: A `line_rst` bit clears all three request bits of that line at the next edge.
- R7: The effective line count is `lines_cfg`, with 0 read as 1 and values above NLINES read as NLINES. Set strobes on lines at or above that count are ignored, and any bits those lines hold are cleared at the next edge. `window_bytes` equals 8 times the effective count.
- R8: When a set and any clear (strobe, line reset or acknowledge) hit the same bit in the same cycle, the bit ends up clear.
- R9: When `in_ack` and `out_ack` are high in the same cycle, only the input side is served. `vec_out` carries the input result and no transmit bit changes.
- R10: After reset all request bits are zero, both master requests are low and `vec_out` is zero. `vec_out` keeps its value in every cycle that has no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lines_cfg | input | CFG_W | Number of lines in use (clamped to 1..NLINES) |
| vec_base | input | VEC_W | Base of the vector space |
| rx_set | input | NLINES | Per-line receive request set strobes |
| rx_clr | input | NLINES | Per-line receive request clear strobes |
| ds_set | input | NLINES | Per-line modem-change request set strobes |
| ds_clr | input | NLINES | Per-line modem-change request clear strobes |
| tx_set | input | NLINES | Per-line transmit request set strobes |
| tx_clr | input | NLINES | Per-line transmit request clear strobes |
| line_rst | input | NLINES | Per-line reset of all three request bits |
| in_ack | input | 1 | Input-side acknowledge pulse |
| out_ack | input | 1 | Output-side acknowledge pulse |
| in_req | output | 1 | Input master request |
| out_req | output | 1 | Output master request |
| vec_out | output | VEC_W | Registered vector of the last acknowledge |
| window_bytes | output | WIN_W | Register window size in bytes |

## Verification
Two collisions can fall in one cycle. The first is an acknowledge meeting a new set strobe for the line it selects. The second is the two acknowledges arriving together. The bench provokes both on purpose: it sets a line's receive bit in the same cycle that an input acknowledge retires that line, and it raises both acknowledges while both sides have requests pending. A bench-side model built from the requirements judges the outcome. Under that model the clear beats the set, and the output side must keep its transmit bits and leave the vector to the input result. A long pseudo-random phase then lets strobes, resets and acknowledges overlap freely while every output is compared against the model.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    localparam int IDX_W = 8;

    typedef enum logic {
        SIDE_IN  = 1'b0,
        SIDE_OUT = 1'b1
    } ack_side_e;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } pick_t;

    localparam int SLOT_BYTES = 8;
    localparam int OUT_OFFSET = 4;

    function automatic logic [31:0] line_vector(input logic [31:0] base,
                                                input logic [IDX_W-1:0] idx,
                                                input ack_side_e side);
        logic [31:0] v;
        v = base + 32'(idx) * 32'(SLOT_BYTES);
        if (side == SIDE_OUT) v = v + 32'(OUT_OFFSET);
        return v;
    endfunction

endpackage

// File: rtl/lirq_req_bank.sv
module lirq_req_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);
    logic [N-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= (bits_q | set_i) & ~clr_i;
    end

    assign bits_o = bits_q;
endmodule

// File: rtl/lirq_first_set.sv
module lirq_first_set
    import lirq_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] req_i,
    output pick_t        pick_o
);
    always_comb begin
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pick_o.found = 1'b1;
                pick_o.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/line_irq_arbiter.sv
module line_irq_arbiter
    import lirq_pkg::*;
#(
    parameter  int NLINES = 16,
    parameter  int VEC_W  = 9,
    localparam int CFG_W  = $clog2(NLINES + 1),
    localparam int WIN_W  = $clog2(NLINES * SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  lines_cfg,
    input  logic [VEC_W-1:0]  vec_base,
    input  logic [NLINES-1:0] rx_set,
    input  logic [NLINES-1:0] rx_clr,
    input  logic [NLINES-1:0] ds_set,
    input  logic [NLINES-1:0] ds_clr,
    input  logic [NLINES-1:0] tx_set,
    input  logic [NLINES-1:0] tx_clr,
    input  logic [NLINES-1:0] line_rst,
    input  logic              in_ack,
    input  logic              out_ack,
    output logic              in_req,
    output logic              out_req,
    output logic [VEC_W-1:0]  vec_out,
    output logic [WIN_W-1:0]  window_bytes
);
    logic [CFG_W-1:0]  eff_lines;
    logic [NLINES-1:0] active;
    logic [NLINES-1:0] rx_bits, ds_bits, tx_bits;
    logic [NLINES-1:0] in_hit, out_hit;
    logic [NLINES-1:0] kill;
    pick_t             in_pick, out_pick;
    logic              in_take, out_take;
    logic [VEC_W-1:0]  vec_q;

    // Line-count clamp and window size
    always_comb begin
        if (lines_cfg == '0)                    eff_lines = CFG_W'(1);
        else if (lines_cfg > CFG_W'(NLINES))    eff_lines = CFG_W'(NLINES);
        else                                    eff_lines = lines_cfg;
    end

    assign window_bytes = WIN_W'(eff_lines) * WIN_W'(SLOT_BYTES);

    for (genvar g = 0; g < NLINES; g++) begin : g_active
        assign active[g] = (CFG_W'(g) < eff_lines);
    end

    // Acknowledge selection; input side wins a tie
    assign in_take  = in_ack;
    assign out_take = out_ack & ~in_ack;

    lirq_first_set #(.N(NLINES)) u_in_pick (
        .req_i  (rx_bits | ds_bits),
        .pick_o (in_pick)
    );

    lirq_first_set #(.N(NLINES)) u_out_pick (
        .req_i  (tx_bits),
        .pick_o (out_pick)
    );

    assign in_hit  = (in_take && in_pick.found)   ? (NLINES'(1) << in_pick.idx)  : '0;
    assign out_hit = (out_take && out_pick.found) ? (NLINES'(1) << out_pick.idx) : '0;
    assign kill    = line_rst | ~active;

    // Request bitmaps; clear beats set inside each bank
    lirq_req_bank #(.N(NLINES)) u_rx_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (rx_set & active),
        .clr_i  (rx_clr | kill | in_hit),
        .bits_o (rx_bits)
    );

    lirq_req_bank #(.N(NLINES)) u_ds_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ds_set & active),
        .clr_i  (ds_clr | kill | in_hit),
        .bits_o (ds_bits)
    );

    lirq_req_bank #(.N(NLINES)) u_tx_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (tx_set & active),
        .clr_i  (tx_clr | kill | out_hit),
        .bits_o (tx_bits)
    );

    assign in_req  = |(rx_bits | ds_bits);
    assign out_req = |tx_bits;

    // Registered vector
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else if (in_take) begin
            vec_q <= in_pick.found
                   ? VEC_W'(line_vector(32'(vec_base), in_pick.idx, SIDE_IN)) : '0;
        end else if (out_take) begin
            vec_q <= out_pick.found
                   ? VEC_W'(line_vector(32'(vec_base), out_pick.idx, SIDE_OUT)) : '0;
        end
    end

    assign vec_out = vec_q;
endmodule

// File: rtl/lirq_checker.sv
module lirq_checker #(
    parameter int NLINES = 16,
    parameter int VEC_W  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [NLINES-1:0] rx_set,
    input logic [NLINES-1:0] rx_clr,
    input logic [NLINES-1:0] ds_clr,
    input logic [NLINES-1:0] tx_clr,
    input logic [NLINES-1:0] line_rst,
    input logic              in_ack,
    input logic              out_ack,
    input logic              in_req,
    input logic              out_req,
    input logic [VEC_W-1:0]  vec_out
);
    // R1: a set on line 0 (always enabled) with no clear raises in_req
    a_r1_set_raises: assert property (@(posedge clk) disable iff (rst)
        (rx_set[0] && !rx_clr[0] && !line_rst[0] && !in_ack) |=> in_req);

    // R3: input acknowledge with nothing pending yields vector zero
    a_r3_idle_in_zero: assert property (@(posedge clk) disable iff (rst)
        (in_ack && !in_req) |=> (vec_out == '0));

    // R5: output acknowledge with nothing pending yields vector zero
    a_r5_idle_out_zero: assert property (@(posedge clk) disable iff (rst)
        (out_ack && !in_ack && !out_req) |=> (vec_out == '0));

    // R6: resetting every line drops both master requests
    a_r6_all_reset: assert property (@(posedge clk) disable iff (rst)
        (&line_rst) |=> (!in_req && !out_req));

    // R8: clearing every input bit wins over any set
    a_r8_in_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (&rx_clr && &ds_clr) |=> !in_req);

    // R8: clearing every transmit bit wins over any set
    a_r8_out_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (&tx_clr) |=> !out_req);

    // R10: vector holds when no acknowledge arrives
    a_r10_vec_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_ack && !out_ack) |=> $stable(vec_out));

    // R2/R4: a vector from a served acknowledge has the right slot offset
    a_r4_out_offset: assert property (@(posedge clk) disable iff (rst)
        (out_ack && !in_ack && out_req) |=> (vec_out[1:0] == 2'b00));
endmodule

bind line_irq_arbiter lirq_checker #(.NLINES(NLINES), .VEC_W(VEC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rx_set   (rx_set),
    .rx_clr   (rx_clr),
    .ds_clr   (ds_clr),
    .tx_clr   (tx_clr),
    .line_rst (line_rst),
    .in_ack   (in_ack),
    .out_ack  (out_ack),
    .in_req   (in_req),
    .out_req  (out_req),
    .vec_out  (vec_out)
);

// File: tb/line_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module line_irq_arbiter_tb_top;
    localparam int N     = 16;
    localparam int VW    = 9;
    localparam int CW    = $clog2(N + 1);
    localparam int WW    = $clog2(N * 8 + 1);
    localparam int BASE  = 9'o300;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] lines_cfg;
    logic [VW-1:0] vec_base;
    logic [N-1:0]  rx_set, rx_clr, ds_set, ds_clr, tx_set, tx_clr, line_rst;
    logic          in_ack, out_ack;
    logic          in_req, out_req;
    logic [VW-1:0] vec_out;
    logic [WW-1:0] window_bytes;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [N-1:0]  m_rx, m_ds, m_tx;
    logic [VW-1:0] m_vec;

    always #10 clk = ~clk;

    line_irq_arbiter #(.NLINES(N), .VEC_W(VW)) dut_i (
        .clk(clk), .rst(rst), .lines_cfg(lines_cfg), .vec_base(vec_base),
        .rx_set(rx_set), .rx_clr(rx_clr), .ds_set(ds_set), .ds_clr(ds_clr),
        .tx_set(tx_set), .tx_clr(tx_clr), .line_rst(line_rst),
        .in_ack(in_ack), .out_ack(out_ack), .in_req(in_req), .out_req(out_req),
        .vec_out(vec_out), .window_bytes(window_bytes)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_set = '0; rx_clr = '0; ds_set = '0; ds_clr = '0;
        tx_set = '0; tx_clr = '0; line_rst = '0; in_ack = 0; out_ack = 0;
    endtask

    function automatic int eff_count();
        if (lines_cfg == 0) return 1;
        if (int'(lines_cfg) > N) return N;
        return int'(lines_cfg);
    endfunction

    // One clock: model update from requirements, then compare after the edge
    task automatic tick(input string tag);
        logic [N-1:0] act, kill, ihit, ohit, pend;
        int il, ol, e;
        e = eff_count();
        act = '0;
        for (int i = 0; i < N; i++) if (i < e) act[i] = 1'b1;
        kill = line_rst | ~act;
        pend = m_rx | m_ds;
        il = -1; ol = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) il = i;
            if (m_tx[i]) ol = i;
        end
        ihit = '0; ohit = '0;
        if (in_ack) begin
            if (il >= 0) begin ihit[il] = 1'b1; m_vec = VW'(BASE + 8 * il); end
            else m_vec = '0;
        end else if (out_ack) begin
            if (ol >= 0) begin ohit[ol] = 1'b1; m_vec = VW'(BASE + 8 * ol + 4); end
            else m_vec = '0;
        end
        m_rx = (m_rx | (rx_set & act)) & ~(rx_clr | kill | ihit);
        m_ds = (m_ds | (ds_set & act)) & ~(ds_clr | kill | ihit);
        m_tx = (m_tx | (tx_set & act)) & ~(tx_clr | kill | ohit);
        @(posedge clk);
        @(negedge clk);
        check(tag, "in_req", int'(in_req), int'(|(m_rx | m_ds)));
        check(tag, "out_req", int'(out_req), int'(|m_tx));
        check(tag, "vec_out", int'(vec_out), int'(m_vec));
        check("R7", "window_bytes", int'(window_bytes), 8 * e);
        idle_inputs();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        lines_cfg = CW'(N);
        vec_base  = VW'(BASE);
        m_rx = '0; m_ds = '0; m_tx = '0; m_vec = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        check("R10", "in_req", int'(in_req), 0);
        check("R10", "out_req", int'(out_req), 0);
        check("R10", "vec_out", int'(vec_out), 0);

        // R1/R2/R4: single line sweeps over each source
        for (int l = 0; l < N; l++) begin
            rx_set[l] = 1'b1; tick("R1");
            in_ack = 1;       tick("R2");
            ds_set[l] = 1'b1; tick("R1");
            in_ack = 1;       tick("R2");
            tx_set[l] = 1'b1; tick("R1");
            out_ack = 1;      tick("R4");
            tick("R10");
        end

        // R2/R3: ordering over a full receive map, then an empty ack
        rx_set = '1; tick("R1");
        for (int k = 0; k < N; k++) begin in_ack = 1; tick("R2"); end
        in_ack = 1; tick("R3");
        // R4/R5: ordering over a full transmit map, then an empty ack
        tx_set = '1; tick("R1");
        for (int k = 0; k < N; k++) begin out_ack = 1; tick("R4"); end
        out_ack = 1; tick("R5");

        // R2: receive and modem bits of one line retired by one ack
        rx_set[5] = 1; ds_set[5] = 1; ds_set[9] = 1; tick("R1");
        in_ack = 1; tick("R2");
        in_ack = 1; tick("R2");
        in_ack = 1; tick("R3");

        // R8: set with clear on the same bit
        rx_set[3] = 1; rx_clr[3] = 1; tx_set[7] = 1; tx_clr[7] = 1; tick("R8");
        ds_set[2] = 1; line_rst[2] = 1; tick("R8");
        rx_set[4] = 1; tick("R1");
        rx_set[4] = 1; in_ack = 1; tick("R8");

        // R6: line reset clears all three bits of that line only
        rx_set[6] = 1; ds_set[6] = 1; tx_set[6] = 1; tx_set[8] = 1; tick("R1");
        line_rst[6] = 1; tick("R6");
        out_ack = 1; tick("R6");

        // R9: both acks in one cycle
        rx_set[10] = 1; tx_set[1] = 1; tick("R1");
        in_ack = 1; out_ack = 1; tick("R9");
        in_ack = 1; out_ack = 1; tick("R9");
        out_ack = 1; tick("R4");

        // R7: reduced and clamped line counts
        rx_set = '1; tx_set = '1; tick("R1");
        lines_cfg = CW'(4); tick("R7");
        rx_set = '1; tick("R7");
        for (int k = 0; k < 5; k++) begin in_ack = 1; tick("R7"); end
        lines_cfg = '0; tx_set = '1; tick("R7");
        out_ack = 1; tick("R7");
        out_ack = 1; tick("R7");
        lines_cfg = CW'(N + 7); tick("R7");
        lines_cfg = CW'(N);

        // Mixed pseudo-random traffic
        for (int c = 0; c < 4000; c++) begin
            rx_set = N'($urandom & $urandom & $urandom);
            ds_set = N'($urandom & $urandom & $urandom & $urandom);
            tx_set = N'($urandom & $urandom & $urandom);
            rx_clr = N'($urandom & $urandom & $urandom & $urandom);
            ds_clr = N'($urandom & $urandom & $urandom & $urandom);
            tx_clr = N'($urandom & $urandom & $urandom & $urandom);
            line_rst = N'($urandom & $urandom & $urandom & $urandom & $urandom);
            in_ack  = ($urandom % 3) == 0;
            out_ack = ($urandom % 3) == 0;
            if (($urandom % 64) == 0) lines_cfg = CW'($urandom % (N + 3));
            tick("R1");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule